// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 64-word, 16-bit serial EEPROM that answers on a three-wire bus: a select line, a serial clock and a data input, with one data output. All logic runs on a fast system clock. The three bus pins are synchronized into that clock, and rising edges of the serial clock are found by edge detection. Each instruction is a start bit, a two-bit opcode and a six-bit address. Write-type instructions then carry a 16-bit data word.

The block keeps its words in a register array and supports five operations: reading one word, writing one word, erasing one word to all ones, filling the whole array with one word, and erasing the whole array. An enable latch gates all programming. The latch is clear after reset, set by an enable command and cleared by a disable command. Every programming operation runs a self-timed cycle whose length is a parameter counted in system clocks. The array is updated when that cycle ends.

While the cycle runs, the host can drop the select line and raise it again. The data output then shows 0 for busy and 1 once the cycle is done. When the output carries neither read data nor status, it is released, which is shown by an output-enable flag.

Top module: `eep_slave`

## Requirements
- R1: Bits are taken from the data input on each serial-clock rising edge while select is high, most significant bit first. Zeros before the first 1 are skipped. That 1 is the start bit, and it is followed by two opcode bits and six address bits.
- R2: The opcodes are 10 read, 01 write and 11 erase. Opcode 00 takes its command from the top two address bits: 11 enable programming, 00 disable programming, 10 erase the whole array, 01 fill the whole array. The other four address bits are ignored.
- R3: After the last address bit of a read, the output is driven low as a dummy bit. The next 16 serial-clock rising edges put out the word most significant bit first. The 17th rising edge releases the output.
- R4: The enable latch is clear after reset. It is set by the enable command and cleared by the disable command. While it is clear, write, erase, fill and erase-all start no cycle and leave the array unchanged.
- R5: A write stores the 16 data bits that follow the address (first bit received = bit 15) into the addressed word.
- R6: Erase sets the addressed word to FFFF and no other word. Erase-all sets every word to FFFF, which is also the content of every word after reset.
- R7: Fill writes its 16 data bits into every word.
- R8: Each programming cycle lasts PROG_CYCLES system clocks and starts after the last bit of its instruction. Any instruction whose start bit arrives during the cycle has no effect.
- R9: If select rises while a cycle is running, the output is driven 0 until the cycle ends and then 1, until select falls.
- R10: If select rises only after the cycle has ended, no status is driven and the output stays released.
- R11: Lowering select drops a partly received instruction. The decoder then waits for a new start bit, and no cycle starts.
- R12: The output is released after reset and whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bus select, active high |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdin | input | 1 | Serial data input |
| sdout | output | 1 | Serial data output: read data or ready/busy |
| sdout_en | output | 1 | High while sdout is driven, low when released |

## Verification
Each address gets its own arithmetic pattern that mixes high and low bits. Writing all 64 of them and reading them back separates address decoding from data shifting, and catches an address or bit order that is swapped or off by one. A uniform fill word, a full erase and a single-word erase with unchanged neighbours show the difference between broadcast writes and addressed writes. The negative cases check at the ports that nothing happened:
- programming while the latch is clear,
- an instruction sent during the busy cycle,
- an instruction cut off by select,
- select raised late after a cycle.

Each of these is followed by a status probe and a read-back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_RD, S_WD, S_HOLD} fsm_t;
  typedef enum logic [2:0] {P_NONE, P_WORD, P_CLEAR, P_FILL, P_WIPE} prog_t;

  localparam logic [1:0] OPC_RD  = 2'b10;
  localparam logic [1:0] OPC_WR  = 2'b01;
  localparam logic [1:0] OPC_ER  = 2'b11;

  localparam logic [1:0] EXT_EN    = 2'b11;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_DIS   = 2'b00;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_rise
);
  logic [STAGES:0]   cs_q;
  logic [STAGES:0]   sk_q;
  logic [STAGES-1:0] di_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      sk_q <= '0;
      di_q <= '0;
    end else begin
      cs_q <= {cs_q[STAGES-1:0], cs};
      sk_q <= {sk_q[STAGES-1:0], sk};
      di_q <= {di_q[STAGES-2:0], di};
    end
  end

  assign cs_s    = cs_q[STAGES-1];
  assign di_s    = di_q[STAGES-1];
  assign sk_rise = sk_q[STAGES-1] & ~sk_q[STAGES];
  assign cs_rise = cs_q[STAGES-1] & ~cs_q[STAGES];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              cs_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              prog_go,
  output prog_t             prog_op,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              wen,
  output logic              stat_on,
  output logic              dout,
  output logic              dout_en
);
  localparam int CW = $clog2(DATA_W + 1);

  fsm_t              state;
  prog_t             wd_op;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] sh;
  logic              ign;
  logic              rd_on;
  logic              rd_bit;

  wire [ADDR_W-1:0] adr_nx   = {adr[ADDR_W-2:0], di_s};
  wire [DATA_W-1:0] sh_nx    = {sh[DATA_W-2:0], di_s};
  wire [1:0]        ext      = adr_nx[ADDR_W-1 -: 2];
  wire              may_run  = !busy && !ign;
  wire              may_prog = may_run && wen;

  assign dout    = stat_on ? !busy : rd_bit;
  assign dout_en = stat_on | rd_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wd_op     <= P_NONE;
      cnt       <= '0;
      opc       <= '0;
      adr       <= '0;
      sh        <= '0;
      ign       <= 1'b0;
      rd_on     <= 1'b0;
      rd_bit    <= 1'b0;
      wen       <= 1'b0;
      stat_on   <= 1'b0;
      prog_go   <= 1'b0;
      prog_op   <= P_NONE;
      prog_addr <= '0;
      prog_data <= '0;
      rd_addr   <= '0;
    end else begin
      prog_go <= 1'b0;
      if (!cs_s) begin
        state   <= S_IDLE;
        cnt     <= '0;
        rd_on   <= 1'b0;
        stat_on <= 1'b0;
        ign     <= 1'b0;
      end else begin
        if (cs_rise && busy) stat_on <= 1'b1;
        if (sk_rise) begin
          case (state)
            S_IDLE: if (di_s) begin
              state <= S_OPC;
              cnt   <= '0;
              ign   <= busy;
              if (!busy) stat_on <= 1'b0;
            end
            S_OPC: begin
              opc <= {opc[0], di_s};
              if (cnt == CW'(1)) begin
                state <= S_ADR;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_ADR: begin
              adr <= adr_nx;
              if (cnt == CW'(ADDR_W - 1)) begin
                cnt   <= '0;
                state <= S_HOLD;
                case (opc)
                  OPC_RD: if (may_run) begin
                    state   <= S_RD;
                    rd_addr <= adr_nx;
                    rd_on   <= 1'b1;
                    rd_bit  <= 1'b0;
                  end
                  OPC_WR: begin
                    state <= S_WD;
                    wd_op <= P_WORD;
                  end
                  OPC_ER: if (may_prog) begin
                    prog_go   <= 1'b1;
                    prog_op   <= P_CLEAR;
                    prog_addr <= adr_nx;
                  end
                  default: begin
                    case (ext)
                      EXT_EN:    if (may_run) wen <= 1'b1;
                      EXT_DIS:   if (may_run) wen <= 1'b0;
                      EXT_ERALL: if (may_prog) begin
                        prog_go <= 1'b1;
                        prog_op <= P_WIPE;
                      end
                      default: begin
                        state <= S_WD;
                        wd_op <= P_FILL;
                      end
                    endcase
                  end
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_RD: begin
              if (cnt == CW'(DATA_W)) begin
                rd_on  <= 1'b0;
                rd_bit <= 1'b0;
                state  <= S_HOLD;
              end else begin
                if (cnt == '0) begin
                  rd_bit <= rd_word[DATA_W-1];
                  sh     <= {rd_word[DATA_W-2:0], 1'b0};
                end else begin
                  rd_bit <= sh[DATA_W-1];
                  sh     <= {sh[DATA_W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
              end
            end
            S_WD: begin
              sh <= sh_nx;
              if (cnt == CW'(DATA_W - 1)) begin
                state <= S_HOLD;
                cnt   <= '0;
                if (may_prog) begin
                  prog_go   <= 1'b1;
                  prog_op   <= wd_op;
                  prog_addr <= adr;
                  prog_data <= sh_nx;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  prog_t             op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              apply,
  output prog_t             ap_op,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_data
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      apply   <= 1'b0;
      tcnt    <= '0;
      ap_op   <= P_NONE;
      ap_addr <= '0;
      ap_data <= '0;
    end else begin
      apply <= 1'b0;
      if (go && !busy) begin
        busy    <= 1'b1;
        tcnt    <= '0;
        ap_op   <= op;
        ap_addr <= addr;
        ap_data <= data;
      end else if (busy) begin
        if (tcnt == TW'(PROG_CYCLES - 1)) begin
          busy  <= 1'b0;
          apply <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  prog_t             op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (apply) begin
      for (int i = 0; i < DEPTH; i++) begin
        case (op)
          P_WORD:  if (addr == ADDR_W'(i)) mem[i] <= data;
          P_CLEAR: if (addr == ADDR_W'(i)) mem[i] <= '1;
          P_FILL:  mem[i] <= data;
          P_WIPE:  mem[i] <= '1;
          default: ;
        endcase
      end
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_en
);
  logic              cs_s, di_s, sk_rise, cs_rise;
  logic              busy, apply, wen, stat_on, prog_go;
  prog_t             prog_op, ap_op;
  logic [ADDR_W-1:0] rd_addr, prog_addr, ap_addr;
  logic [DATA_W-1:0] rd_word, prog_data, ap_data;

  eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(sel), .sk(sclk), .di(sdin),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_rise(cs_rise)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise),
    .cs_rise(cs_rise), .di_s(di_s), .busy(busy), .rd_word(rd_word),
    .rd_addr(rd_addr), .prog_go(prog_go), .prog_op(prog_op),
    .prog_addr(prog_addr), .prog_data(prog_data), .wen(wen),
    .stat_on(stat_on), .dout(sdout), .dout_en(sdout_en)
  );

  eep_prog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(prog_go), .op(prog_op),
    .addr(prog_addr), .data(prog_data), .busy(busy), .apply(apply),
    .ap_op(ap_op), .ap_addr(ap_addr), .ap_data(ap_data)
  );

  eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(apply), .op(ap_op),
    .addr(ap_addr), .data(ap_data), .rd_addr(rd_addr), .rd_word(rd_word)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk #(
  parameter int PROG_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic busy,
  input logic wen,
  input logic stat_on,
  input logic apply,
  input logic sdout,
  input logic sdout_en
);
  int bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= 0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!wen && !sdout_en && !busy)); // R4

  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen)); // R4

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == PROG_CYCLES)); // R8

  AST_APPLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> ($past(busy) && !busy)); // R8

  AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_on && busy) |-> (sdout_en && !sdout)); // R9

  AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_on && !busy) |-> (sdout_en && sdout)); // R9

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdout_en); // R12
endmodule

bind eep_slave eep_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy), .wen(wen),
  .stat_on(stat_on), .apply(apply), .sdout(sdout), .sdout_en(sdout_en)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
  localparam int PC = 40;

  logic clk = 1'b0;
  logic rst_n, sel, sclk, sdin;
  logic sdout, sdout_en;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #2 clk = ~clk;

  eep_slave #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sdout_en(sdout_en)
  );

  function automatic logic [15:0] pat(input int a);
    logic [31:0] p;
    p = a * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic tick(input logic b);
    sdin = b;
    repeat (4) @(posedge clk);
    sclk = 1'b1;
    repeat (4) @(posedge clk);
    sclk = 1'b0;
  endtask

  task automatic shift_out(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic cs_up;
    sel = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic cs_down;
    sel = 1'b0;
    sdin = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic instr(input logic [1:0] op, input logic [5:0] a);
    cs_up();
    tick(1'b1);
    shift_out({30'd0, op}, 2);
    shift_out({26'd0, a}, 6);
  endtask

  task automatic body_read(input string req, input logic [15:0] exp);
    logic [15:0] v;
    @(negedge clk);
    check({req, " dummy"}, {30'd0, sdout_en, sdout}, 32'd2);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b0);
      @(negedge clk);
      v = {v[14:0], sdout};
    end
    check({req, " word"}, {16'd0, v}, {16'd0, exp});
    tick(1'b0);
    @(negedge clk);
    check({req, " release"}, {31'd0, sdout_en}, 32'd0);
    cs_down();
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [15:0] exp,
                          input string req);
    instr(2'b10, a);
    body_read(req, exp);
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a,
                      input logic [15:0] d, input bit has_data);
    instr(op, a);
    if (has_data) shift_out({16'd0, d}, 16);
    cs_down();
  endtask

  task automatic wait_status(input string req);
    cs_up();
    @(negedge clk);
    check({req, " busy"}, {30'd0, sdout_en, sdout}, 32'd2);
    repeat (PC + 20) @(posedge clk);
    @(negedge clk);
    check({req, " ready"}, {30'd0, sdout_en, sdout}, 32'd3);
    cs_down();
    @(negedge clk);
    check("R12 release on select low", {31'd0, sdout_en}, 32'd0);
  endtask

  task automatic probe_idle(input string req);
    cs_up();
    @(negedge clk);
    check(req, {31'd0, sdout_en}, 32'd0);
    cs_down();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdin = 1'b0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset release", {31'd0, sdout_en}, 32'd0);

    // R4: latch clear after reset, write ignored
    prog(2'b01, 6'd2, 16'hABCD, 1);
    probe_idle("R4 no cycle while disabled");
    read_chk(6'd2, 16'hFFFF, "R4 R6 reset content kept");

    // R2: enable command (00, top bits 11)
    prog(2'b00, 6'b110000, 16'h0, 0);

    // R5 R9: write every address with its own pattern
    for (int a = 0; a < 64; a++) begin
      prog(2'b01, 6'(a), pat(a), 1);
      wait_status("R9 write status");
    end
    for (int a = 0; a < 64; a++) read_chk(6'(a), pat(a), "R3 R5 read back");

    // R1: leading zeros before the start bit
    cs_up();
    tick(1'b0); tick(1'b0); tick(1'b0);
    tick(1'b1);
    shift_out(32'b10, 2);
    shift_out(32'd10, 6);
    body_read("R1 leading zeros", pat(10));

    // R8: instruction during busy cycle ignored
    prog(2'b01, 6'd3, 16'h1111, 1);
    cs_up();
    @(negedge clk);
    check("R9 busy before ignored instr", {30'd0, sdout_en, sdout}, 32'd2);
    tick(1'b1);
    shift_out(32'b01, 2);
    shift_out(32'd4, 6);
    shift_out(32'h2222, 16);
    cs_down();
    repeat (PC + 20) @(posedge clk);
    read_chk(6'd3, 16'h1111, "R8 first write done");
    read_chk(6'd4, pat(4), "R8 busy instr ignored");

    // R10: select raised after the cycle ended
    prog(2'b01, 6'd5, 16'h5555, 1);
    repeat (PC + 60) @(posedge clk);
    probe_idle("R10 no late status");
    read_chk(6'd5, 16'h5555, "R10 write landed");

    // R11: aborted write
    cs_up();
    tick(1'b1);
    shift_out(32'b01, 2);
    shift_out(32'd9, 6);
    shift_out(32'hA5, 8);
    cs_down();
    probe_idle("R11 abort starts no cycle");
    read_chk(6'd9, pat(9), "R11 aborted word intact");

    // R6 R2: single erase (opcode 11)
    prog(2'b11, 6'd7, 16'h0, 0);
    wait_status("R9 erase status");
    read_chk(6'd7, 16'hFFFF, "R6 erased word");
    read_chk(6'd6, pat(6), "R6 neighbour below");
    read_chk(6'd8, pat(8), "R6 neighbour above");

    // R7 R2: fill (00, top bits 01)
    prog(2'b00, 6'b010000, 16'h3C96, 1);
    wait_status("R9 fill status");
    for (int a = 0; a < 64; a++) read_chk(6'(a), 16'h3C96, "R7 fill");

    // R6 R2: erase all (00, top bits 10)
    prog(2'b00, 6'b101111, 16'h0, 0);
    wait_status("R9 erase-all status");
    for (int a = 0; a < 64; a += 3) read_chk(6'(a), 16'hFFFF, "R6 erase all");

    // R4 R2: disable command (00, top bits 00) then write ignored
    prog(2'b00, 6'b001010, 16'h0, 0);
    prog(2'b01, 6'd1, 16'h0F0F, 1);
    probe_idle("R4 no cycle after disable");
    prog(2'b00, 6'b100000, 16'h0, 0);
    probe_idle("R4 erase-all blocked after disable");
    read_chk(6'd1, 16'hFFFF, "R4 word unchanged");

    summary();
  end
endmodule